// File: doc/BRIEF.md
# Multi-channel gamma lookup table

This block applies per-channel colour correction to a pixel stream that carries pixels of several display channels. Every channel owns three 256-entry tables of 8-bit values, one per colour component. When correction is switched on for a pixel's channel, each of the pixel's red, green and blue components is replaced by the table entry it indexes. When correction is off, the pixel passes through unchanged with the same one-cycle latency, so downstream timing never depends on the enables.

All tables live in one flat address space and are loaded as a single stream of writes. Software loads an address together with an auto-increment flag, then writes data values one after another. Each channel occupies 768 consecutive entries, and the components are laid out in the order red, green, blue. After reset the tables hold the identity mapping. The table storage may also power down while every channel has correction disabled, and it loses its contents when that happens. This is modelled as a hardware refill with the identity mapping, and the real tables must then be loaded again.

Top module: `gamma_lut`

## Requirements
- R1: A data write stores its value at flat address channel*768 + component*256 + entry, where component 0 is red, 1 is green and 2 is blue. A pixel of that channel whose component value equals the entry then reads that value.
- R2: Loading the address register also loads the auto-increment flag. With the flag at 1, each accepted data write advances the address by one, wrapping modulo 2^ADDR_W. With the flag at 0, the address stays put, so repeated writes hit the same entry.
- R3: `out_valid` is high exactly one cycle after `pix_valid`, and the output components for that pixel are present in that same cycle.
- R4: When `gamma_en[ch]` is 1, the pixel's components are replaced by the table entries. When it is 0, or when `pix_ch` is NUM_CH or above, the components come out unchanged with the same latency.
- R5: When a data write and a lookup of the same entry occur in the same cycle, the lookup returns the newly written value.
- R6: After the last reset cycle, the block fills every table with the identity mapping (entry i holds i) over NUM_CH*256 cycles, which is 768 cycles with the default parameters.
- R7: While a fill is running, data writes are discarded and do not advance the address. Address loads are still accepted.
- R8: When `gamma_en` goes from non-zero to all zero, the table contents are lost. A new identity fill starts in the following cycle and follows the same rules as R6 and R7.
- R9: A data write to an address of NUM_CH*768 or above is discarded. With auto-increment set, the address still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gamma_en | input | NUM_CH | Per-channel correction enable |
| addr_load | input | 1 | Load the table address register |
| addr_autoinc | input | 1 | Auto-increment flag loaded with the address |
| addr_value | input | ADDR_W | Flat table address to load |
| data_wr | input | 1 | Write strobe for one table entry |
| data_value | input | 8 | Table entry value |
| pix_valid | input | 1 | Input pixel valid |
| pix_ch | input | CH_W | Channel of the input pixel |
| pix_r | input | 8 | Red component in |
| pix_g | input | 8 | Green component in |
| pix_b | input | 8 | Blue component in |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red component out |
| out_g | output | 8 | Green component out |
| out_b | output | 8 | Blue component out |

## Verification
The bench goes after the cases where a table write and a lookup collide. It does this by looking up an entry in the same cycle it is written; a design that returned the stale value would show the old entry for one pixel. It tries writes during the reset fill and during the power-down refill. If those writes leaked through, or if they moved the address, later values would land at the wrong entries. It wraps the address from the top of its range back to zero and sends pixels on disabled and non-existent channels. A wrong channel-base decode, a missed wrap or a lookup on a disabled channel would then show up as a wrong component at the output.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int COMP_N  = 3;
  localparam int ENT_W   = 8;
  localparam int ENT_N   = 1 << ENT_W;
  localparam int CH_SPAN = COMP_N * ENT_N;

  typedef logic [ENT_W-1:0] comp_t;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;
endpackage

// File: rtl/gamma_bank.sv
module gamma_bank
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH = 768,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  comp_t         wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output comp_t         rdata
);
  comp_t mem [DEPTH];

  // Single write port, single registered read port; a collision on the
  // same entry forwards the incoming data.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= (we && (waddr == raddr)) ? wdata : mem[raddr];
  end
endmodule

// File: rtl/gamma_wr_ctrl.sv
module gamma_wr_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 12,
  parameter int BA_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic              addr_load,
  input  logic              addr_autoinc,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              data_wr,
  input  comp_t             data_value,
  output logic [COMP_N-1:0] bank_we,
  output logic [BA_W-1:0]   bank_waddr,
  output comp_t             bank_wdata
);
  localparam int TOTAL  = NUM_CH * CH_SPAN;
  localparam int FILL_N = NUM_CH * ENT_N;

  logic [ADDR_W-1:0]  addr_q;
  logic               inc_q;
  logic               busy_q;
  logic [BA_W-1:0]    fill_ptr;
  logic               any_en_q;
  logic               any_en;
  logic [ADDR_W-1:0]  ch_base;
  logic [BA_W-1:0]    ch_idx;
  logic [ENT_W+1:0]   rem;
  logic               in_range;
  logic               prog_we;
  comp_e              sel_comp;

  assign any_en = |gamma_en;

  // Channel base by comparison against multiples of the channel span.
  always_comb begin
    ch_base = '0;
    ch_idx  = '0;
    for (int c = 1; c < NUM_CH; c++) begin
      if (addr_q >= ADDR_W'(c * CH_SPAN)) begin
        ch_base = ADDR_W'(c * CH_SPAN);
        ch_idx  = BA_W'(c);
      end
    end
    rem = (ENT_W+2)'(addr_q - ch_base);
  end

  assign in_range = addr_q < ADDR_W'(TOTAL);
  assign prog_we  = data_wr && !busy_q && in_range;
  assign sel_comp = comp_e'(rem[ENT_W+1:ENT_W]);

  always_comb begin
    if (busy_q) begin
      bank_we    = '1;
      bank_waddr = fill_ptr;
      bank_wdata = fill_ptr[ENT_W-1:0];
    end else begin
      for (int c = 0; c < COMP_N; c++)
        bank_we[c] = prog_we && (sel_comp == comp_e'(c));
      bank_waddr = (ch_idx << ENT_W) | BA_W'(rem[ENT_W-1:0]);
      bank_wdata = data_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      inc_q    <= 1'b0;
      busy_q   <= 1'b1;
      fill_ptr <= '0;
      any_en_q <= 1'b0;
    end else begin
      any_en_q <= any_en;
      if (addr_load) begin
        addr_q <= addr_value;
        inc_q  <= addr_autoinc;
      end else if (data_wr && !busy_q && inc_q) begin
        addr_q <= addr_q + 1'b1;
      end
      if (any_en_q && !any_en) begin
        busy_q   <= 1'b1;
        fill_ptr <= '0;
      end else if (busy_q) begin
        if (fill_ptr == BA_W'(FILL_N - 1)) busy_q <= 1'b0;
        fill_ptr <= fill_ptr + 1'b1;
      end
    end
  end

  AST_PROG_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> $onehot0(bank_we)); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!data_wr && !addr_load) |=> $stable(addr_q)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !busy_q && inc_q && !addr_load) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1))); // R2
  AST_FILL_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !addr_load) |=> $stable(addr_q)); // R7
  AST_POWERDOWN_FILL: assert property (@(posedge clk) disable iff (rst)
    (any_en_q && !any_en) |=> busy_q); // R8
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int ADDR_W = $clog2(NUM_CH * CH_SPAN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic              addr_load,
  input  logic              addr_autoinc,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              data_wr,
  input  logic [7:0]        data_value,
  input  logic              pix_valid,
  input  logic [CH_W-1:0]   pix_ch,
  input  logic [7:0]        pix_r,
  input  logic [7:0]        pix_g,
  input  logic [7:0]        pix_b,
  output logic              out_valid,
  output logic [7:0]        out_r,
  output logic [7:0]        out_g,
  output logic [7:0]        out_b
);
  localparam int BANK_DEPTH = NUM_CH * ENT_N;
  localparam int BA_W       = $clog2(BANK_DEPTH);

  logic [COMP_N-1:0] bank_we;
  logic [BA_W-1:0]   bank_waddr;
  comp_t             bank_wdata;
  logic              lut_sel;
  logic              sel_q;
  comp_t             pix_c   [COMP_N];
  comp_t             pass_q  [COMP_N];
  comp_t             rd_data [COMP_N];
  comp_t             out_c   [COMP_N];
  logic [BA_W-1:0]   rd_addr [COMP_N];

  assign pix_c[0] = pix_r;
  assign pix_c[1] = pix_g;
  assign pix_c[2] = pix_b;

  always_comb begin
    lut_sel = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (pix_ch == CH_W'(c) && gamma_en[c]) lut_sel = 1'b1;
  end

  gamma_wr_ctrl #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_wr_ctrl (
    .clk          (clk),
    .rst          (rst),
    .gamma_en     (gamma_en),
    .addr_load    (addr_load),
    .addr_autoinc (addr_autoinc),
    .addr_value   (addr_value),
    .data_wr      (data_wr),
    .data_value   (data_value),
    .bank_we      (bank_we),
    .bank_waddr   (bank_waddr),
    .bank_wdata   (bank_wdata)
  );

  for (genvar k = 0; k < COMP_N; k++) begin : g_comp
    assign rd_addr[k] = (BA_W'(pix_ch) << ENT_W) | BA_W'(pix_c[k]);

    gamma_bank #(
      .DEPTH (BANK_DEPTH),
      .AW    (BA_W)
    ) u_bank (
      .clk   (clk),
      .we    (bank_we[k]),
      .waddr (bank_waddr),
      .wdata (bank_wdata),
      .re    (pix_valid && lut_sel),
      .raddr (rd_addr[k]),
      .rdata (rd_data[k])
    );

    always_ff @(posedge clk) pass_q[k] <= pix_c[k];

    assign out_c[k] = sel_q ? rd_data[k] : pass_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      out_valid <= pix_valid;
      sel_q     <= pix_valid && lut_sel;
    end
  end

  assign out_r = out_c[0];
  assign out_g = out_c[1];
  assign out_b = out_c[2];

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid); // R3
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid); // R3
  AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !lut_sel) |=> (out_r == $past(pix_r) && out_g == $past(pix_g)
                                 && out_b == $past(pix_b))); // R4
  AST_WRITE_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && lut_sel && bank_we[0] && bank_waddr == rd_addr[0])
      |=> (out_r == $past(bank_wdata))); // R5
endmodule

// File: tb/gamma_lut_tb_top.sv
module gamma_lut_tb_top;
  localparam int NUM_CH = 3;
  localparam int CH_W   = 2;
  localparam int ADDR_W = 12;
  localparam int TOTAL  = NUM_CH * 768;
  localparam int FILL_N = NUM_CH * 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] gamma_en = '0;
  logic              addr_load = 1'b0;
  logic              addr_autoinc = 1'b0;
  logic [ADDR_W-1:0] addr_value = '0;
  logic              data_wr = 1'b0;
  logic [7:0]        data_value = '0;
  logic              pix_valid = 1'b0;
  logic [CH_W-1:0]   pix_ch = '0;
  logic [7:0]        pix_r = '0, pix_g = '0, pix_b = '0;
  logic              out_valid;
  logic [7:0]        out_r, out_g, out_b;

  always #5 clk = ~clk;

  gamma_lut #(.NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst(rst), .gamma_en(gamma_en),
    .addr_load(addr_load), .addr_autoinc(addr_autoinc), .addr_value(addr_value),
    .data_wr(data_wr), .data_value(data_value),
    .pix_valid(pix_valid), .pix_ch(pix_ch), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // Behavioural reference model: flat table, address counter, fill countdown.
  int    mem_m [TOTAL];
  int    addr_m, inc_m, fill_left, en_prev_m;
  bit    exp_valid = 1'b0;
  int    exp_c [3];
  bit    started = 1'b0;
  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R3";
  bit    done = 1'b0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      fill_left = FILL_N; addr_m = 0; inc_m = 0; en_prev_m = 0; exp_valid = 1'b0;
    end else begin
      if (fill_left > 0) begin
        int p;
        p = FILL_N - fill_left;
        for (int c = 0; c < 3; c++) mem_m[(p / 256) * 768 + c * 256 + (p % 256)] = p % 256;
        fill_left--;
      end else if (data_wr) begin
        if (addr_m < TOTAL) mem_m[addr_m] = data_value;
        if (inc_m != 0) addr_m = (addr_m + 1) % 4096;
      end
      exp_valid = pix_valid;
      if (pix_valid) begin
        bit use_tab;
        int v [3];
        use_tab = 1'b0;
        for (int c = 0; c < NUM_CH; c++) if (int'(pix_ch) == c && gamma_en[c]) use_tab = 1'b1;
        v[0] = pix_r; v[1] = pix_g; v[2] = pix_b;
        for (int c = 0; c < 3; c++)
          exp_c[c] = use_tab ? mem_m[int'(pix_ch) * 768 + c * 256 + v[c]] : v[c];
      end
      if (addr_load) begin addr_m = addr_value; inc_m = addr_autoinc; end
      if (en_prev_m != 0 && gamma_en == '0) fill_left = FILL_N;
      en_prev_m = (gamma_en != '0);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      int act [3];
      act[0] = out_r; act[1] = out_g; act[2] = out_b;
      vectors++;
      if (out_valid !== exp_valid) begin
        miscompares++;
        $display("FAIL %s: out_valid actual %0b expected %0b", cur_req, out_valid, exp_valid);
      end else if (exp_valid) begin
        for (int c = 0; c < 3; c++)
          if (act[c] !== exp_c[c]) begin
            miscompares++;
            $display("FAIL %s: component %0d actual %0d expected %0d", cur_req, c, act[c], exp_c[c]);
          end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    data_wr = 1'b0; addr_load = 1'b0; pix_valid = 1'b0;
  endtask

  task automatic load_addr(int a, bit inc);
    tick(); addr_load = 1'b1; addr_value = ADDR_W'(a); addr_autoinc = inc;
  endtask

  task automatic wr(int v);
    tick(); data_wr = 1'b1; data_value = 8'(v);
  endtask

  task automatic pix(int ch, int r, int g, int b);
    tick(); pix_valid = 1'b1; pix_ch = CH_W'(ch);
    pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R3: watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R7: writes during the reset fill are dropped and do not move the address
    cur_req = "R7";
    load_addr(0, 1'b1);
    wr(8'hAA); wr(8'hBB);
    repeat (780) tick();
    gamma_en = 3'b111;
    pix(0, 0, 0, 0);
    wr(8'h33);
    pix(0, 0, 1, 2);
    // R6: identity contents after the fill
    cur_req = "R6";
    for (int v = 1; v < 256; v++) pix(v % 3, v, 255 - v, (v * 3) & 255);
    // R3: bursts with bubbles
    cur_req = "R3";
    for (int i = 0; i < 40; i++) begin
      if (i % 3 != 0) pix(i % 3, i * 5, i * 7, i * 11); else tick();
    end
    // R1: load channel 1 as one stream, red then green then blue
    cur_req = "R1";
    load_addr(768, 1'b1);
    for (int i = 0; i < 768; i++)
      wr(i < 256 ? 255 - i : (i < 512 ? ((i & 255) ^ 8'h5A) : ((i * 7) & 255)));
    for (int v = 0; v < 256; v += 5) pix(1, v, v + 1, v + 2);
    for (int v = 0; v < 40; v++) pix((v % 2) * 2, v * 6, v * 3, v);
    // R2: without auto-increment repeated writes land on one entry
    cur_req = "R2";
    load_addr(2 * 768 + 256 + 10, 1'b0);
    wr(1); wr(2); wr(3);
    pix(2, 0, 10, 0); pix(2, 0, 11, 0); pix(2, 10, 10, 10);
    // R5: same-cycle write and lookup of one entry
    cur_req = "R5";
    load_addr(50, 1'b0);
    tick(); data_wr = 1'b1; data_value = 8'd99;
    pix_valid = 1'b1; pix_ch = 2'd0; pix_r = 8'd50; pix_g = 8'd1; pix_b = 8'd2;
    pix(0, 50, 50, 50);
    // R4: disabled channel and non-existent channel pass through
    cur_req = "R4";
    gamma_en = 3'b101;
    for (int v = 0; v < 20; v++) pix(1, v * 13, v * 9, v * 4);
    for (int v = 0; v < 10; v++) pix(3, v * 17, v, 200 - v);
    pix(0, 50, 7, 8);
    gamma_en = 3'b111;
    pix(1, 0, 0, 0);
    // R9: out-of-range writes dropped, address still wraps to zero
    cur_req = "R9";
    load_addr(4095, 1'b1);
    wr(8'h77); wr(8'h44);
    pix(0, 0, 0, 0);
    load_addr(TOTAL, 1'b1);
    wr(8'h11); wr(8'h12);
    pix(2, 255, 255, 255); pix(0, 0, 0, 0); pix(1, 255, 0, 0);
    // R8: power-down loses contents, refill restores identity
    cur_req = "R8";
    gamma_en = 3'b000;
    repeat (800) tick();
    gamma_en = 3'b111;
    for (int v = 0; v < 256; v += 3) pix(v % 3, v, 255 - v, v ^ 8'h0F);
    pix(0, 50, 0, 0); pix(2, 0, 10, 0);
    repeat (3) tick();
    finish_run();
  end
endmodule